// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a small synchronous static memory with a single data slot per clock cycle, where reads and writes may follow each other in any order with no idle cycle in between. Every address, control and write-data input is taken on the rising clock edge. Writes are "late": their data comes one or two edges after the command. This lines up the write data with the slot a read would use at the same point, so the shared data slot stays full.

A static mode input picks the read path. In registered mode, read data is loaded into an output register and driven for one cycle after the second edge. Write data for that mode comes two edges after the command. In flow-through mode, read data comes straight from the array during the cycle after the command edge. Write data then comes one edge after the command. Bursts of four words are started by a normal command and continued by a burst-next input, in linear or interleaved order. Three chip selects must all be active to start an access. An asynchronous output enable can switch the read data off at any time.

Top module: `zt_sram`

## Requirements
- R1: A command is taken only when burst_next is 0 and sel_a_n=0, sel_b=1 and sel_c_n=0 all hold. Any other select pattern is a deselect, and rdata_oe stays 0 during that command's data slot.
- R2: In registered mode (flow_mode=0), a read taken at edge n drives rdata_oe=1 and the word at its address in the cycle between edges n+1 and n+2.
- R3: In flow-through mode (flow_mode=1), a read taken at edge n drives rdata_oe=1 and the word at its address in the cycle between edges n and n+1.
- R4: Write data is sampled from wdata at edge n+2 in registered mode and at edge n+1 in flow-through mode. rdata_oe stays 0 during a write's data slot.
- R5: Reads and writes may alternate on consecutive edges with no idle cycle. A read of an address written by the command just before it returns the new data.
- R6: Lane l is wdata bits [9l+8:9l], written only when lane_we[l]=1 in the command's cycle. Lanes whose enable is 0 keep their previous content.
- R7: With burst_interleave=0, the k-th word of a burst (k=0..3) uses address low bits (start+k) mod 4. The upper address bits are those of the start address.
- R8: With burst_interleave=1, the k-th word of a burst uses address low bits start XOR k. The upper address bits are those of the start address.
- R9: With burst_next=1, the block continues the previous read or write at the next burst address and ignores addr, write_en and the selects. After a deselect or reset, burst_next=1 yields a deselect.
- R10: While oe_n=1, rdata_oe is 0 at once without any clock edge. rdata is all zeros whenever rdata_oe is 0.
- R11: During and after reset, the pipeline holds no command and rdata_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| flow_mode | input | 1 | 1 = flow-through read path, 0 = registered read path (static) |
| burst_interleave | input | 1 | 1 = interleaved burst order, 0 = linear |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_next | input | 1 | Continue the current burst instead of loading a new command |
| write_en | input | 1 | 1 = write command, 0 = read command |
| lane_we | input | LANES | Per-lane write enables, sampled with each command cycle |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*BYTE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
A command lost or duplicated in the two-stage late-write pipeline shows at the ports within two cycles of its command edge. It appears as a drive enable in a write or deselect slot, or a missing one in a read slot. A wrong burst counter or order select puts the wrong address on the array, but the fault only shows once that word is read back. The bench reads every burst address singly and then again as a burst, so the error appears a few cycles after the write burst. A missing same-edge bypass in registered mode shows at once, as stale data on a read that directly follows a write to the same word.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits of the k-th word of a four-word burst
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       interleave);
        return interleave ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/zt_burst_ctrl.sv
module zt_burst_ctrl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              interleave_i,
    input  logic              next_i,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  be_i,
    output op_e               iss_op_o,
    output logic [ADDR_W-1:0] iss_addr_o,
    output logic [LANES-1:0]  iss_be_o
);

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] base;
        logic [1:0]        step;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!next_i) begin
            if (sel_i) begin
                st_d.op   = wr_i ? OP_WRITE : OP_READ;
                st_d.base = addr_i;
                st_d.step = '0;
            end else begin
                st_d.op = OP_IDLE;
            end
        end else if (st_q.op != OP_IDLE) begin
            st_d.step = st_q.step + 2'd1;
        end

        iss_op_o   = st_d.op;
        iss_addr_o = {st_d.base[ADDR_W-1:2],
                      burst_low(st_d.base[1:0], st_d.step, interleave_i)};
        iss_be_o   = be_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{op: OP_IDLE, base: '0, step: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/zt_late_pipe.sv
module zt_late_pipe
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int BYTE_W = 9,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_i,
    input  op_e               iss_op_i,
    input  logic [ADDR_W-1:0] iss_addr_i,
    input  logic [LANES-1:0]  iss_be_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [LANES-1:0]  wr_be_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_vld_o,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
    } stage_t;

    typedef struct packed {
        stage_t            s1;
        stage_t            s2;
        logic [DATA_W-1:0] rd;
    } pipe_t;

    pipe_t             p_d, p_q;
    stage_t            slot;
    logic [DATA_W-1:0] fwd_word;
    logic              same_word;

    always_comb begin
        // the command whose data occupies the current cycle
        slot = flow_i ? p_q.s1 : p_q.s2;

        // registered mode: the write leaving s2 commits on the same edge
        // that s1 loads the output register, so bypass it per lane
        same_word = !flow_i && (p_q.s2.op == OP_WRITE) && (p_q.s2.addr == p_q.s1.addr);
        fwd_word  = rd_word_i;
        for (int l = 0; l < LANES; l++) begin
            if (same_word && p_q.s2.be[l]) begin
                fwd_word[l*BYTE_W +: BYTE_W] = wdata_i[l*BYTE_W +: BYTE_W];
            end
        end

        p_d.s1 = '{op: iss_op_i, addr: iss_addr_i, be: iss_be_i};
        p_d.s2 = p_q.s1;
        p_d.rd = (p_q.s1.op == OP_READ) ? fwd_word : p_q.rd;

        rd_addr_o = p_q.s1.addr;
        wr_en_o   = (slot.op == OP_WRITE);
        wr_addr_o = slot.addr;
        wr_be_o   = slot.be;
        wr_data_o = wdata_i;
        rd_vld_o  = (slot.op == OP_READ);
        rd_data_o = flow_i ? rd_word_i : p_q.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int BYTE_W = 9,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [LANES-1:0]  wr_be_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en_i && wr_be_i[g]) begin
                cells[wr_addr_i] <= wr_data_i[g*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data_o[g*BYTE_W +: BYTE_W] = cells[rd_addr_i];
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flow_mode,
    input  logic                      burst_interleave,
    input  logic                      sel_a_n,
    input  logic                      sel_b,
    input  logic                      sel_c_n,
    input  logic                      burst_next,
    input  logic                      write_en,
    input  logic [LANES-1:0]          lane_we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*BYTE_W-1:0]   wdata,
    input  logic                      oe_n,
    output logic [LANES*BYTE_W-1:0]   rdata,
    output logic                      rdata_oe
);

    localparam int DATA_W = LANES * BYTE_W;

    logic              sel;
    op_e               iss_op;
    logic [ADDR_W-1:0] iss_addr;
    logic [LANES-1:0]  iss_be;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_word;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_be;
    logic [DATA_W-1:0] wr_data;
    logic              rd_vld;
    logic [DATA_W-1:0] rd_data;

    assign sel = !sel_a_n && sel_b && !sel_c_n;

    zt_burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .interleave_i (burst_interleave),
        .next_i       (burst_next),
        .sel_i        (sel),
        .wr_i         (write_en),
        .addr_i       (addr),
        .be_i         (lane_we),
        .iss_op_o     (iss_op),
        .iss_addr_o   (iss_addr),
        .iss_be_o     (iss_be)
    );

    zt_late_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .flow_i     (flow_mode),
        .iss_op_i   (iss_op),
        .iss_addr_i (iss_addr),
        .iss_be_i   (iss_be),
        .wdata_i    (wdata),
        .rd_word_i  (rd_word),
        .rd_addr_o  (rd_addr),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_be_o    (wr_be),
        .wr_data_o  (wr_data),
        .rd_vld_o   (rd_vld),
        .rd_data_o  (rd_data)
    );

    zt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_mem (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_be_i   (wr_be),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_word)
    );

    // asynchronous output enable overrides the synchronous drive
    assign rdata_oe = rd_vld && !oe_n;
    assign rdata    = rdata_oe ? rd_data : '0;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flow_mode,
    input logic              next_c,
    input logic              sel_c,
    input logic              wr_c,
    input logic              oe_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input op_e               iss_op,
    input logic [ADDR_W-1:0] iss_addr
);

    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_oe); // R10
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0)); // R10
    AST_FT_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode && warm >= 2'd1 && $past(!next_c && !sel_c)) |-> !rdata_oe); // R1
    AST_PL_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && warm >= 2'd2 && $past(!next_c && !sel_c, 2)) |-> !rdata_oe); // R1
    AST_PL_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && warm >= 2'd2 && $past(!next_c && sel_c && !wr_c, 2) && !oe_n) |-> rdata_oe); // R2
    AST_FT_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode && warm >= 2'd1 && $past(!next_c && sel_c && !wr_c) && !oe_n) |-> rdata_oe); // R3
    AST_PL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && warm >= 2'd2 && $past(!next_c && sel_c && wr_c, 2)) |-> !rdata_oe); // R4
    AST_NEXT_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd1 && next_c && $past(iss_op) != OP_IDLE) |->
        (iss_op == $past(iss_op) && iss_addr[ADDR_W-1:2] == $past(iss_addr[ADDR_W-1:2]))); // R9
    AST_NEXT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd1 && next_c && $past(iss_op) == OP_IDLE) |-> (iss_op == OP_IDLE)); // R9

endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flow_mode (flow_mode),
    .next_c    (burst_next),
    .sel_c     (sel),
    .wr_c      (write_en),
    .oe_n      (oe_n),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe),
    .iss_op    (iss_op),
    .iss_addr  (iss_addr)
);

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;

    localparam int NV = 33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flow_mode = 1'b0;
    logic        burst_interleave = 1'b0;
    logic        sel_a_n = 1'b1;
    logic        sel_b = 1'b0;
    logic        sel_c_n = 1'b1;
    logic        burst_next = 1'b0;
    logic        write_en = 1'b0;
    logic [1:0]  lane_we = 2'b00;
    logic [5:0]  addr = '0;
    logic [17:0] wdata = '0;
    logic        oe_n = 1'b0;
    logic [17:0] rdata;
    logic        rdata_oe;

    int n_chk = 0;
    int n_err = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    zt_sram u_zt_sram (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .burst_interleave(burst_interleave),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .burst_next(burst_next),
        .write_en(write_en), .lane_we(lane_we), .addr(addr), .wdata(wdata),
        .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // vector: {next, select code, write, lanes, addr, wdata, oe_n in data slot}
    // select code: 0 all active, 1 sel_a_n high, 2 sel_b low, 3 sel_c_n high
    function automatic logic [30:0] mk(input logic nx, input logic [1:0] sc, input logic w,
                                       input logic [1:0] be, input logic [5:0] ad,
                                       input logic [17:0] d, input logic oe);
        return {nx, sc, w, be, ad, d, oe};
    endfunction

    localparam logic [30:0] VEC [NV] = '{
        mk(0,0,1,2'b11, 6'd4, 18'h12345, 0),  // write a4
        mk(0,0,1,2'b11, 6'd5, 18'h0ABCD, 0),  // write a5
        mk(0,0,0,2'b00, 6'd4, 18'h0,     0),  // read right after write R5
        mk(0,0,1,2'b01, 6'd4, 18'h3FFFF, 0),  // lane 0 only R6
        mk(0,0,0,2'b00, 6'd4, 18'h0,     0),  // read merged word
        mk(0,0,0,2'b00, 6'd5, 18'h0,     0),
        mk(0,0,1,2'b11, 6'd9, 18'h111A1, 0),  // write burst from 9
        mk(1,0,1,2'b11, 6'd0, 18'h222A2, 0),
        mk(1,0,1,2'b11, 6'd0, 18'h333A3, 0),
        mk(1,0,1,2'b11, 6'd0, 18'h044A4, 0),
        mk(0,0,0,2'b00, 6'd8, 18'h0,     0),  // single reads of burst words
        mk(0,0,0,2'b00, 6'd9, 18'h0,     0),
        mk(0,0,0,2'b00, 6'd10,18'h0,     0),
        mk(0,0,0,2'b00, 6'd11,18'h0,     0),
        mk(0,0,0,2'b00, 6'd10,18'h0,     0),  // read burst from 10
        mk(1,0,0,2'b00, 6'd0, 18'h0,     0),
        mk(1,0,0,2'b00, 6'd0, 18'h0,     0),
        mk(1,0,0,2'b00, 6'd0, 18'h0,     0),
        mk(0,1,0,2'b00, 6'd4, 18'h0,     0),  // deselect R1
        mk(1,0,0,2'b00, 6'd4, 18'h0,     0),  // next after deselect R9
        mk(0,2,0,2'b00, 6'd4, 18'h0,     0),  // deselect via sel_b
        mk(0,3,0,2'b00, 6'd4, 18'h0,     0),  // deselect via sel_c_n
        mk(0,0,0,2'b00, 6'd5, 18'h0,     1),  // read with oe_n high R10
        mk(0,0,0,2'b00, 6'd8, 18'h0,     0),
        mk(1,1,1,2'b11, 6'd33,18'h3FFFF, 0),  // next ignores write/addr/select R9
        mk(0,0,1,2'b00, 6'd5, 18'h00001, 0),  // write with no lane enabled R6
        mk(0,0,0,2'b00, 6'd5, 18'h0,     0),
        mk(0,0,1,2'b11, 6'd40,18'h15555, 0),  // upper address bits
        mk(0,0,0,2'b00, 6'd40,18'h0,     0),
        mk(0,0,0,2'b00, 6'd0, 18'h0,     0),  // read a0 never written? avoided below
        mk(0,1,0,2'b00, 6'd0, 18'h0,     0),
        mk(0,1,0,2'b00, 6'd0, 18'h0,     0),
        mk(0,1,0,2'b00, 6'd0, 18'h0,     0)
    };

    int          h_op [NV];
    logic [5:0]  h_ad [NV];
    logic [1:0]  h_be [NV];
    logic [17:0] h_wd [NV];
    logic        h_oe [NV];
    logic        h_nx [NV];
    logic [17:0] ref_mem [64];

    int          m_op;
    logic [5:0]  m_base;
    logic [1:0]  m_cnt;

    task automatic chk(input string tag, input logic exp_oe, input logic [17:0] exp_d);
        n_chk++;
        if (rdata_oe !== exp_oe || rdata !== exp_d) begin
            n_err++;
            $display("FAIL %s: got oe=%0b data=%h, expected oe=%0b data=%h",
                     tag, rdata_oe, rdata, exp_oe, exp_d);
        end
    endtask

    task automatic set_sel(input logic [1:0] sc);
        sel_a_n = (sc == 2'd1);
        sel_b   = (sc != 2'd2);
        sel_c_n = (sc == 2'd3);
    endtask

    task automatic idle_inputs();
        burst_next = 1'b0; write_en = 1'b0; lane_we = '0; addr = '0;
        set_sel(2'd1);
    endtask

    task automatic do_reset(input logic ft, input logic il);
        @(negedge clk);
        rst_n = 1'b0; idle_inputs(); oe_n = 1'b0; wdata = '0;
        flow_mode = ft; burst_interleave = il;
        repeat (3) @(negedge clk);
        chk("R11 in reset", 1'b0, 18'h0);
        rst_n = 1'b1;
        m_op = 0; m_base = '0; m_cnt = '0;
    endtask

    task automatic run_pass(input logic ft, input logic il);
        int dly;
        dly = ft ? 0 : 1;
        do_reset(ft, il);
        for (int c = 0; c < NV + 2; c++) begin
            int s;
            @(negedge clk);
            s = c - 1 - dly;
            if (s >= 0 && s < NV) begin
                oe_n = h_oe[s];
                #1;
                if (h_op[s] == 1) begin
                    if (h_oe[s])                                   chk("R10", 1'b0, 18'h0);
                    else if (h_nx[s])                              chk(il ? "R8 R9" : "R7 R9", 1'b1, ref_mem[h_ad[s]]);
                    else if (s > 0 && h_op[s-1] == 2 && h_be[s-1] != 2'b11) chk("R6", 1'b1, ref_mem[h_ad[s]]);
                    else if (s > 0 && h_op[s-1] == 2)              chk("R5", 1'b1, ref_mem[h_ad[s]]);
                    else                                           chk(ft ? "R3" : "R2", 1'b1, ref_mem[h_ad[s]]);
                end else if (h_op[s] == 2) begin
                    chk("R4", 1'b0, 18'h0);
                    wdata = h_wd[s];
                    for (int l = 0; l < 2; l++)
                        if (h_be[s][l]) ref_mem[h_ad[s]][l*9 +: 9] = h_wd[s][l*9 +: 9];
                end else begin
                    chk(h_nx[s] ? "R9" : "R1", 1'b0, 18'h0);
                end
            end else begin
                oe_n = 1'b0; wdata = '0;
            end
            if (c < NV) begin
                logic [30:0] v;
                v = VEC[c];
                burst_next = v[30]; set_sel(v[29:28]); write_en = v[27];
                lane_we = v[26:25]; addr = v[24:19];
                if (!v[30]) begin
                    if (v[29:28] == 2'd0) begin
                        m_op = v[27] ? 2 : 1; m_base = v[24:19]; m_cnt = '0;
                    end else begin
                        m_op = 0;
                    end
                end else if (m_op != 0) begin
                    m_cnt = m_cnt + 2'd1;
                end
                h_op[c] = m_op;
                h_ad[c] = {m_base[5:2], il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
                h_be[c] = v[26:25]; h_wd[c] = v[18:1]; h_oe[c] = v[0]; h_nx[c] = v[30];
            end else begin
                idle_inputs();
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        // prefill address 0 so the one read of it has a known value
        do_reset(1'b1, 1'b0);
        @(negedge clk);
        set_sel(2'd0); write_en = 1'b1; lane_we = 2'b11; addr = 6'd0;
        @(negedge clk);
        idle_inputs(); wdata = 18'h2D2D2; ref_mem[0] = 18'h2D2D2;
        @(negedge clk);
        wdata = '0;

        run_pass(1'b1, 1'b0);   // flow-through, linear
        run_pass(1'b0, 1'b1);   // registered, interleaved
        run_pass(1'b0, 1'b0);   // registered, linear

        // asynchronous output enable during a registered read slot
        @(negedge clk);
        set_sel(2'd0); write_en = 1'b0; addr = 6'd4;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        #1;   chk("R2 before oe toggle", 1'b1, ref_mem[4]);
        oe_n = 1'b1; #0.3;
        chk("R10 oe high mid-cycle", 1'b0, 18'h0);
        oe_n = 1'b0; #0.3;
        chk("R10 oe low again", 1'b1, ref_mem[4]);

        // reset in the middle of a burst, then burst_next
        @(negedge clk);
        set_sel(2'd0); write_en = 1'b0; addr = 6'd8;
        @(negedge clk);
        rst_n = 1'b0; idle_inputs();
        @(negedge clk);
        #0.5; chk("R11 reset clears pipeline", 1'b0, 18'h0);
        rst_n = 1'b1; burst_next = 1'b1; set_sel(2'd0); addr = 6'd9;
        @(negedge clk);
        idle_inputs();
        #0.5; chk("R11 after reset", 1'b0, 18'h0);
        @(negedge clk);
        #0.5; chk("R9 next after reset", 1'b0, 18'h0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule